// File: doc/BRIEF.md
# Scheduled Pulse Output Unit

This block drives one digital output with single pulses placed at exact instants on a free-running 16-bit microsecond time base. A host hands over pulse descriptors. Each descriptor carries an absolute rising-edge time, a falling-edge offset in microseconds and a sequence number. A descriptor is taken only when its sequence number is exactly one above the last one taken. Taken descriptors wait in a small in-order queue. The unit plays them out one at a time, and it compares every time through the wrap-aware signed difference between the event time and the current time.

The host can read the enable value back, along with the sequence number of the newest descriptor taken, so it can tell whether a write landed. If a descriptor's rising time has already passed when that descriptor reaches the head of the queue, the unit latches an error and stops. To restart it, the host writes the enable to zero, pulses the acknowledge while the enable reads zero, and then writes the enable back on.

Top module: `tsp_pulse_sched`

## Requirements
- R1: After reset, `en_rb` is 0, `seq_rb` is 0, `late_err` is 0 and `pulse_out` is 0. A write on `en_wr` stores `en_val`, which reads back on `en_rb` from the next cycle. The unit runs only while `en_rb` is nonzero and `late_err` is 0.
- R2: A write on `desc_wr` is accepted only when all three of these hold:
  - the unit runs;
  - the queue is not full;
  - `desc_seq` equals `seq_rb` + 1 (modulo 256).

  On acceptance, `seq_rb` takes `desc_seq` in the next cycle. Any other write leaves `seq_rb` unchanged.
- R3: The queue holds at most 12 descriptors, and the count includes the one currently being played. While 12 are held, a further write is refused and `seq_rb` keeps the last accepted number.
- R4: For the descriptor at the head of the queue, `pulse_out` goes to 1 after the clock edge where `tick` is 1 and `now_us` equals the rising time.
- R5: `pulse_out` returns to 0 after the edge where `tick` is 1 and `now_us` equals rising time + offset (modulo 2^16). That descriptor then leaves the queue.
- R6: An offset of 0 is treated as 1, so the fall comes one microsecond after the rise.
- R7: Descriptors are played strictly in the order they were accepted, one pulse per descriptor.
- R8: On a tick where the head descriptor is waiting for its rise, a negative signed 16-bit value of (rising time − `now_us`) sets `late_err`. When that happens:
  - `pulse_out` stays 0;
  - the queue is emptied;
  - no further descriptor is accepted or played.
- R9: `late_err` stays set until `err_ack` is 1 in a cycle where `en_rb` is 0. An acknowledge while `en_rb` is nonzero has no effect.
- R10: While `en_rb` is 0, the queue is emptied and `pulse_out` is 0 from the following edge on. This cuts short a pulse in progress.
- R11: Times are compared through the signed 16-bit difference. A rising time just past the wrap of `now_us` (for example 0xFFFE seen at 0xFFF0, and a fall at 0x0004) is therefore treated as future.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_us | input | 16 | Current microsecond time base |
| tick | input | 1 | One-cycle strobe marking a microsecond step |
| en_wr | input | 1 | Enable register write strobe |
| en_val | input | 8 | Enable value to write |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_seq | input | 8 | Descriptor sequence number |
| desc_rise | input | 16 | Absolute rising-edge time |
| desc_ofs | input | 16 | Falling-edge offset in microseconds |
| err_ack | input | 1 | Late-error acknowledge |
| en_rb | output | 8 | Enable readback |
| seq_rb | output | 8 | Last accepted sequence number |
| late_err | output | 1 | Sticky late-timestamp error |
| pulse_out | output | 1 | Scheduled pulse output |

## Verification
A corrupted queue pointer or count shows up at the output on the very next scheduled edge. The pulse rises at some other descriptor's time, or one too many or too few descriptors are taken near the capacity limit, and the scoreboard sees this on the tick that should have moved the output. A flush that fails to clear the queue becomes visible after a disable/enable cycle: stale descriptors that were scheduled earlier than the new one come out first. A wrong error latch shows up as a refused descriptor or a `late_err` level read back one cycle after the acknowledge or the late tick.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
   localparam int unsigned TSP_TIME_W = 16;
   localparam int unsigned TSP_SEQ_W  = 8;
   localparam int unsigned TSP_EN_W   = 8;
   localparam int unsigned TSP_DEPTH  = 12;

   typedef enum logic {
      GEN_WAIT = 1'b0,
      GEN_HIGH = 1'b1
   } gen_state_t;
endpackage

// File: rtl/tsp_queue.sv
module tsp_queue #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;

   if (DEPTH < 2) begin : g_bad_depth
      $error("tsp_queue: DEPTH must be at least 2");
   end

   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full)  wr_ptr <= wr_nxt;
         if (pop && !empty)  rd_ptr <= rd_nxt;
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
endmodule

// File: rtl/tsp_edge_gen.sv
module tsp_edge_gen
   import tsp_pkg::*;
#(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [TIME_W-1:0] now,
   input  logic              head_valid,
   input  logic [TIME_W-1:0] head_rise,
   input  logic [TIME_W-1:0] head_ofs,
   output logic              pulse,
   output logic              pop,
   output logic              late
);
   gen_state_t               state;
   logic [TIME_W-1:0]        fall_t;
   logic signed [TIME_W-1:0] rise_diff;
   logic                     active;

   assign fall_t    = head_rise + ((head_ofs == '0) ? TIME_W'(1) : head_ofs);
   assign rise_diff = $signed(head_rise - now);
   assign active    = run && tick && head_valid;

   assign late = active && (state == GEN_WAIT) && rise_diff[TIME_W-1];
   assign pop  = active && (state == GEN_HIGH) && (now == fall_t);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         state <= GEN_WAIT;
      end else if (active) begin
         if (state == GEN_WAIT && rise_diff == '0) state <= GEN_HIGH;
         else if (pop)                             state <= GEN_WAIT;
      end
   end

   assign pulse = (state == GEN_HIGH);

   p_rise_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> $past(tick) && $past(head_valid) && $past(now) == $past(head_rise));
   p_fall_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pulse) && $past(run)) |-> $past(tick) && $past(now) == $past(fall_t));
   p_late_keeps_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      late |=> !pulse);
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl #(
   parameter int unsigned SEQ_W = 8,
   parameter int unsigned EN_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic [EN_W-1:0]  en_val,
   input  logic             desc_wr,
   input  logic [SEQ_W-1:0] desc_seq,
   input  logic             q_full,
   input  logic             late,
   input  logic             err_ack,
   output logic             run,
   output logic             accept,
   output logic [EN_W-1:0]  en_reg,
   output logic [SEQ_W-1:0] seq_reg,
   output logic             err
);
   assign run    = (en_reg != '0) && !err;
   assign accept = desc_wr && run && !q_full && (desc_seq == seq_reg + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_reg  <= '0;
         seq_reg <= '0;
         err     <= 1'b0;
      end else begin
         if (en_wr)  en_reg  <= en_val;
         if (accept) seq_reg <= desc_seq;
         if (late)                             err <= 1'b1;
         else if (err_ack && en_reg == '0)     err <= 1'b0;
      end
   end

   p_seq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_wr && desc_seq == seq_reg + 1'b1) |=> $stable(seq_reg));
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(err_ack && en_reg == '0)) |=> err);
endmodule

// File: rtl/tsp_pulse_sched.sv
module tsp_pulse_sched
   import tsp_pkg::*;
#(
   parameter int unsigned TIME_W = TSP_TIME_W,
   parameter int unsigned SEQ_W  = TSP_SEQ_W,
   parameter int unsigned EN_W   = TSP_EN_W,
   parameter int unsigned DEPTH  = TSP_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now_us,
   input  logic              tick,
   input  logic              en_wr,
   input  logic [EN_W-1:0]   en_val,
   input  logic              desc_wr,
   input  logic [SEQ_W-1:0]  desc_seq,
   input  logic [TIME_W-1:0] desc_rise,
   input  logic [TIME_W-1:0] desc_ofs,
   input  logic              err_ack,
   output logic [EN_W-1:0]   en_rb,
   output logic [SEQ_W-1:0]  seq_rb,
   output logic              late_err,
   output logic              pulse_out
);
   localparam int unsigned DW = 2 * TIME_W;

   if (TIME_W < 4) begin : g_bad_time
      $error("tsp_pulse_sched: TIME_W must be at least 4");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("tsp_pulse_sched: SEQ_W must be at least 2");
   end

   logic          run, accept, q_full, q_empty, pop, late;
   logic [DW-1:0] head;

   tsp_ctrl #(.SEQ_W(SEQ_W), .EN_W(EN_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (en_wr),
      .en_val  (en_val),
      .desc_wr (desc_wr),
      .desc_seq(desc_seq),
      .q_full  (q_full),
      .late    (late),
      .err_ack (err_ack),
      .run     (run),
      .accept  (accept),
      .en_reg  (en_rb),
      .seq_reg (seq_rb),
      .err     (late_err)
   );

   tsp_queue #(.WIDTH(DW), .DEPTH(DEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (accept),
      .pop    (pop),
      .flush  (!run),
      .wr_data({desc_rise, desc_ofs}),
      .rd_data(head),
      .empty  (q_empty),
      .full   (q_full)
   );

   tsp_edge_gen #(.TIME_W(TIME_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (tick),
      .now       (now_us),
      .head_valid(!q_empty),
      .head_rise (head[DW-1:TIME_W]),
      .head_ofs  (head[TIME_W-1:0]),
      .pulse     (pulse_out),
      .pop       (pop),
      .late      (late)
   );

   p_disabled_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rb == '0) |=> !pulse_out);
   p_error_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      late_err |=> !pulse_out);
   p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_rb != $past(seq_rb)) |-> (seq_rb == $past(seq_rb) + 1'b1));
endmodule

// File: tb/test_tsp_pulse_sched.sv
module test_tsp_pulse_sched;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] now_us = 16'd100;
   logic        tick = 1'b0;
   logic        en_wr = 1'b0;
   logic [7:0]  en_val = '0;
   logic        desc_wr = 1'b0;
   logic [7:0]  desc_seq = '0;
   logic [15:0] desc_rise = '0;
   logic [15:0] desc_ofs = '0;
   logic        err_ack = 1'b0;
   logic [7:0]  en_rb, seq_rb;
   logic        late_err, pulse_out;

   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;
   logic mon_en = 1'b1;
   logic jump_req = 1'b0;
   logic [15:0] jump_val = '0;
   int tcnt = 0;
   logic prev_p = 1'b0;
   logic [7:0] seq = '0;

   typedef struct { logic [15:0] r; logic [15:0] f; } exp_t;
   exp_t exp_q[$];

   tsp_pulse_sched i_tsp_pulse_sched (
      .clk(clk), .rst_n(rst_n), .now_us(now_us), .tick(tick),
      .en_wr(en_wr), .en_val(en_val), .desc_wr(desc_wr), .desc_seq(desc_seq),
      .desc_rise(desc_rise), .desc_ofs(desc_ofs), .err_ack(err_ack),
      .en_rb(en_rb), .seq_rb(seq_rb), .late_err(late_err), .pulse_out(pulse_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // time base: one tick every 4 clocks, time advances with the tick
   always @(negedge clk) begin
      if (jump_req) begin
         now_us <= jump_val;
         tick   <= 1'b0;
         tcnt   <= 0;
      end else if (tcnt == 3) begin
         tcnt   <= 0;
         tick   <= 1'b1;
         now_us <= now_us + 16'd1;
      end else begin
         tcnt <= tcnt + 1;
         tick <= 1'b0;
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: compares each edge with the scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_en && pulse_out != prev_p) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected edge", int'(now_us), -1);
         end else if (pulse_out) begin
            check(now_us == exp_q[0].r, "R4 rise time", int'(now_us), int'(exp_q[0].r));
         end else begin
            check(now_us == exp_q[0].f, "R5 fall time", int'(now_us), int'(exp_q[0].f));
            void'(exp_q.pop_front());
         end
      end
      prev_p <= pulse_out;
   end

   task automatic set_en(input logic [7:0] v);
      @(negedge clk); en_wr = 1'b1; en_val = v;
      @(negedge clk); en_wr = 1'b0;
   endtask

   task automatic write_desc(input logic [7:0] s, input logic [15:0] r, input logic [15:0] o);
      @(negedge clk); desc_wr = 1'b1; desc_seq = s; desc_rise = r; desc_ofs = o;
      @(negedge clk); desc_wr = 1'b0;
   endtask

   // driver: sends a descriptor that must be accepted and queues the expected edges
   task automatic send(input logic [15:0] r, input logic [15:0] o, input string tag);
      exp_t e;
      seq = seq + 8'd1;
      e.r = r;
      e.f = r + ((o == 16'd0) ? 16'd1 : o);
      exp_q.push_back(e);
      write_desc(seq, r, o);
      check(seq_rb == seq, tag, int'(seq_rb), int'(seq));
   endtask

   task automatic drain();
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
      check(exp_q.size() == 0, "R7 all pulses played", exp_q.size(), 0);
   endtask

   task automatic jump(input logic [15:0] v);
      @(negedge clk); jump_val = v; jump_req = 1'b1;
      @(negedge clk); @(negedge clk); jump_req = 1'b0;
   endtask

   initial begin
      logic [7:0] base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pulse_out == 0, "R1 reset pulse_out", pulse_out, 0);
      check(late_err == 0, "R1 reset late_err", late_err, 0);
      check(seq_rb == 0, "R1 reset seq_rb", seq_rb, 0);
      check(en_rb == 0, "R1 reset en_rb", en_rb, 0);

      // R2: a write while disabled is refused
      write_desc(8'd1, now_us + 16'd20, 16'd3);
      check(seq_rb == 0, "R2 refused while disabled", seq_rb, 0);

      set_en(8'd1);
      check(en_rb == 8'd1, "R1 enable readback", en_rb, 1);

      // R2: a wrong sequence number is refused
      write_desc(8'd5, now_us + 16'd20, 16'd3);
      check(seq_rb == 0, "R2 refused bad seq", seq_rb, 0);

      // R4 R5 R6 R7: three pulses in order
      send(now_us + 16'd20, 16'd5, "R2 accept 1");
      send(now_us + 16'd35, 16'd0, "R6 accept zero offset");
      send(now_us + 16'd45, 16'd7, "R2 accept 3");
      drain();

      // R3: capacity, then R10 flush by disable
      base = seq;
      for (int i = 0; i < 12; i++)
         write_desc(seq + 8'd1 + 8'(i), now_us + 16'd40 + 16'(10 * i), 16'd3);
      check(seq_rb == base + 8'd12, "R3 twelve accepted", seq_rb, int'(base + 8'd12));
      write_desc(base + 8'd13, now_us + 16'd200, 16'd3);
      check(seq_rb == base + 8'd12, "R3 refused when full", seq_rb, int'(base + 8'd12));
      seq = base + 8'd12;
      set_en(8'd0);
      set_en(8'd1);
      send(now_us + 16'd60, 16'd4, "R10 accept after flush");
      drain();

      // R10: a pulse in progress is cut short
      mon_en = 1'b0;
      seq = seq + 8'd1;
      write_desc(seq, now_us + 16'd4, 16'd200);
      for (int i = 0; i < 200 && !pulse_out; i++) @(negedge clk);
      check(pulse_out == 1, "R4 truncation pulse high", pulse_out, 1);
      set_en(8'd0);
      @(negedge clk);
      check(pulse_out == 0, "R10 forced low on disable", pulse_out, 0);
      set_en(8'd1);
      repeat (40) @(negedge clk);
      check(pulse_out == 0, "R10 flushed pulse not resumed", pulse_out, 0);
      mon_en = 1'b1;

      // R8: late rise time
      seq = seq + 8'd1;
      write_desc(seq, now_us - 16'd5, 16'd3);
      repeat (10) @(negedge clk);
      check(late_err == 1, "R8 late error set", late_err, 1);
      check(pulse_out == 0, "R8 output low", pulse_out, 0);
      write_desc(seq + 8'd1, now_us + 16'd20, 16'd3);
      check(seq_rb == seq, "R8 refused while in error", seq_rb, int'(seq));
      // R9: acknowledge while enabled is ignored
      @(negedge clk); err_ack = 1'b1;
      @(negedge clk); err_ack = 1'b0;
      check(late_err == 1, "R9 ack ignored while enabled", late_err, 1);
      set_en(8'd0);
      check(late_err == 1, "R9 disable alone keeps error", late_err, 1);
      @(negedge clk); err_ack = 1'b1;
      @(negedge clk); err_ack = 1'b0;
      check(late_err == 0, "R9 ack while disabled clears", late_err, 0);
      set_en(8'd1);
      send(now_us + 16'd15, 16'd2, "R9 accept after restart");
      drain();

      // R11: wraparound
      jump(16'hFFF0);
      send(16'hFFFE, 16'd6, "R11 accept before wrap");
      send(16'h0008, 16'd0, "R11 accept after wrap");
      drain();
      check(late_err == 0, "R11 no false late", late_err, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule